// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block decides when an on-chip debug unit fires its trace trigger. It receives one-cycle match pulses from several comparator channels, together with a software arm level, a software force-trigger strobe and a table of per-state next-state targets. From these it walks through a disarmed state, three intermediate states and a final (trigger) state. A trace buffer sits downstream and uses the one-clock trigger pulse. The processor core uses the per-channel breakpoint requests. Software reads the 3-bit state code.

A session begins on a rising edge of the arm level. In each intermediate state, every channel has its own programmed destination. When several channels match in the same clock, one fixed priority picks a single winner and the other matches are dropped. A match that reaches the final state, or a force strobe, makes the sequencer spend exactly one clock in the final state and then return to disarmed. It stays there until the arm level is lowered and raised again. Breakpoint requests do not go through the sequencer at all.

Top module: `trig_sequencer`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the disarmed state (code 000), with the trigger pulse and every breakpoint request low.
- R2: The state code is 000 when disarmed, 001/010/011 for intermediate states one to three and 100 for the final state. A rising edge of the arm level moves the sequencer from 000 to 001 in the next clock. An arm level that stays high does not re-arm.
- R3: While the arm level is low, the next state is 000 whatever the current state, and no trigger pulse is produced.
- R4: In intermediate state s (1 to 3), a match on channel c moves the sequencer to the 3-bit target held in bits [((s-1)*NUM_CH+c)*3 +: 3] of the target table. The values 001 to 100 are acted on. The value 000 and the reserved values 101 to 111 make that match ignored.
- R5: When several matches with usable targets arrive in the same clock, a channel whose target is 100 wins first. Otherwise the lowest channel number wins.
- R6: A match that loses arbitration is discarded and causes no transition in any later clock.
- R7: A force-trigger strobe while armed in an intermediate state moves the sequencer to the final state in the next clock, ahead of any comparator match. In the disarmed state the strobe has no effect.
- R8: The final state lasts exactly one clock and is always followed by 000.
- R9: The trigger pulse is high for exactly the one clock in which the state code first shows 100.
- R10: Breakpoint request c equals match c ANDed with breakpoint enable c in the same cycle (combinationally), in every state, armed or not.
- R11: Comparator matches have no effect on the state while the sequencer is disarmed or in the final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_en | input | 1 | Arm level; a rising edge starts a session, low disarms |
| force_trig | input | 1 | One-clock software force-trigger strobe |
| chan_hit | input | NUM_CH | Comparator match pulses, one per channel |
| brk_en | input | NUM_CH | Per-channel breakpoint enables |
| tgt_cfg | input | 3*NUM_CH*3 | Next-state target table, 3 bits per state and channel |
| trig_pulse | output | 1 | One-clock trigger on entry to the final state |
| brk_req | output | NUM_CH | Per-channel immediate breakpoint requests |
| state_code | output | 3 | Current sequencer state |

## Verification
Every state register shows up directly on `state_code`. A wrong transition therefore appears at the ports one clock after the match, strobe or arm change that caused it. An arbitration error shows up as the wrong target code in the very next clock. A loser that is wrongly remembered shows up as a change of state in some later clock with no match present. A wrong trigger shows up in the same clock as the entry to the final state, as a pulse with no 100 code or a 100 code with no pulse. Breakpoint faults are visible in the same cycle as the match.

// File: rtl/trigseq_pkg.sv
package trigseq_pkg;

    localparam int TGT_W      = 3;
    localparam int MID_STATES = 3;

    typedef enum logic [TGT_W-1:0] {
        SQ_IDLE = 3'd0,
        SQ_A    = 3'd1,
        SQ_B    = 3'd2,
        SQ_C    = 3'd3,
        SQ_FIN  = 3'd4
    } seq_st_e;

    typedef struct packed {
        logic             valid;
        logic [TGT_W-1:0] tgt;
    } pick_t;

    // A target is usable when it names an intermediate or the final state.
    function automatic logic tgt_usable(input logic [TGT_W-1:0] t);
        return (t != 3'd0) && (t <= 3'd4);
    endfunction

    function automatic logic is_mid(input seq_st_e s);
        return (s == SQ_A) || (s == SQ_B) || (s == SQ_C);
    endfunction

endpackage

// File: rtl/trigseq_cfgsel.sv
module trigseq_cfgsel
    import trigseq_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  seq_st_e                        st,
    input  logic [MID_STATES*NUM_CH*TGT_W-1:0] cfg,
    output logic [NUM_CH*TGT_W-1:0]        row
);
    localparam int ROW_W = NUM_CH * TGT_W;

    // Pick the row of targets that belongs to the current intermediate state.
    always_comb begin
        row = '0;
        case (st)
            SQ_A:    row = cfg[0*ROW_W +: ROW_W];
            SQ_B:    row = cfg[1*ROW_W +: ROW_W];
            SQ_C:    row = cfg[2*ROW_W +: ROW_W];
            default: row = '0;
        endcase
    end
endmodule

// File: rtl/trigseq_arb.sv
module trigseq_arb
    import trigseq_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0]       hit,
    input  logic [NUM_CH*TGT_W-1:0] tgt_row,
    output pick_t                   pick
);
    pick_t fin_pick;
    pick_t any_pick;

    // Scan from the highest channel down so the lowest index is kept last.
    always_comb begin
        fin_pick = '0;
        any_pick = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (hit[c] && tgt_usable(tgt_row[c*TGT_W +: TGT_W])) begin
                any_pick.valid = 1'b1;
                any_pick.tgt   = tgt_row[c*TGT_W +: TGT_W];
                if (tgt_row[c*TGT_W +: TGT_W] == SQ_FIN) begin
                    fin_pick.valid = 1'b1;
                    fin_pick.tgt   = SQ_FIN;
                end
            end
        end
        pick = fin_pick.valid ? fin_pick : any_pick;
    end
endmodule

// File: rtl/trigseq_brk.sv
module trigseq_brk #(
    parameter int NUM_CH = 3
) (
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] en,
    output logic [NUM_CH-1:0] req
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        assign req[c] = !rst && hit[c] && en[c];
    end
endmodule

// File: rtl/trigseq_fsm.sv
module trigseq_fsm
    import trigseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    arm_en,
    input  logic    force_trig,
    input  pick_t   pick,
    output seq_st_e st,
    output logic    trig
);
    seq_st_e nxt;
    logic    arm_q;

    always_comb begin
        nxt = st;
        if (!arm_en) begin
            nxt = SQ_IDLE;
        end else begin
            case (st)
                SQ_IDLE: if (!arm_q) nxt = SQ_A;
                SQ_A, SQ_B, SQ_C: begin
                    if (force_trig)      nxt = SQ_FIN;
                    else if (pick.valid) nxt = seq_st_e'(pick.tgt);
                end
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            arm_q <= 1'b0;
            trig  <= 1'b0;
        end else begin
            st    <= nxt;
            arm_q <= arm_en;
            trig  <= (nxt == SQ_FIN) && (st != SQ_FIN);
        end
    end
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
    import trigseq_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               arm_en,
    input  logic                               force_trig,
    input  logic [NUM_CH-1:0]                  chan_hit,
    input  logic [NUM_CH-1:0]                  brk_en,
    input  logic [MID_STATES*NUM_CH*TGT_W-1:0] tgt_cfg,
    output logic                               trig_pulse,
    output logic [NUM_CH-1:0]                  brk_req,
    output logic [TGT_W-1:0]                   state_code
);
    seq_st_e                  st;
    logic [NUM_CH*TGT_W-1:0]  row;
    pick_t                    pick;

    trigseq_cfgsel #(.NUM_CH(NUM_CH)) u_sel (
        .st (st),
        .cfg(tgt_cfg),
        .row(row)
    );

    trigseq_arb #(.NUM_CH(NUM_CH)) u_arb (
        .hit    (chan_hit),
        .tgt_row(row),
        .pick   (pick)
    );

    trigseq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .arm_en    (arm_en),
        .force_trig(force_trig),
        .pick      (pick),
        .st        (st),
        .trig      (trig_pulse)
    );

    trigseq_brk #(.NUM_CH(NUM_CH)) u_brk (
        .rst(rst),
        .hit(chan_hit),
        .en (brk_en),
        .req(brk_req)
    );

    assign state_code = st;
endmodule

// File: rtl/trig_sequencer_chk.sv
module trig_sequencer_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              arm_en,
    input logic              force_trig,
    input logic [NUM_CH-1:0] chan_hit,
    input logic [NUM_CH-1:0] brk_en,
    input logic              trig_pulse,
    input logic [NUM_CH-1:0] brk_req,
    input logic [2:0]        state_code
);
    p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
        state_code <= 3'd4);

    p_idle_exit_r2: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0) |=> (state_code == 3'd0 || state_code == 3'd1));

    p_disarm_r3: assert property (@(posedge clk) disable iff (rst)
        !arm_en |=> (state_code == 3'd0 && !trig_pulse));

    p_force_r7: assert property (@(posedge clk) disable iff (rst)
        (arm_en && force_trig && state_code >= 3'd1 && state_code <= 3'd3)
        |=> (state_code == 3'd4));

    p_final_once_r8: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd4) |=> (state_code == 3'd0));

    p_trig_entry_r9: assert property (@(posedge clk) disable iff (rst)
        trig_pulse == (state_code == 3'd4 && $past(state_code) != 3'd4));

    p_brk_gate_r10: assert property (@(posedge clk) disable iff (rst)
        brk_req == (chan_hit & brk_en));
endmodule

bind trig_sequencer trig_sequencer_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .arm_en    (arm_en),
    .force_trig(force_trig),
    .chan_hit  (chan_hit),
    .brk_en    (brk_en),
    .trig_pulse(trig_pulse),
    .brk_req   (brk_req),
    .state_code(state_code)
);

// File: tb/trig_sequencer_tb_top.sv
module trig_sequencer_tb_top;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           arm_en = 1'b0;
    logic           force_trig = 1'b0;
    logic [NCH-1:0] chan_hit = '0;
    logic [NCH-1:0] brk_en = '0;
    logic [3*NCH*3-1:0] tgt_cfg = '0;
    logic           trig_pulse;
    logic [NCH-1:0] brk_req;
    logic [2:0]     state_code;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    trig_sequencer #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .arm_en(arm_en), .force_trig(force_trig),
        .chan_hit(chan_hit), .brk_en(brk_en), .tgt_cfg(tgt_cfg),
        .trig_pulse(trig_pulse), .brk_req(brk_req), .state_code(state_code)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_tgt(input int s, input int c, input logic [2:0] v);
        tgt_cfg[((s-1)*NCH+c)*3 +: 3] = v;
    endtask

    task automatic hit_once(input logic [NCH-1:0] h);
        chan_hit = h;
        tick();
        chan_hit = '0;
    endtask

    task automatic rearm();
        arm_en = 1'b0; tick();
        arm_en = 1'b1; tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; chan_hit = 3'b111; brk_en = 3'b111;
        tick(); tick();
        chk("R1 state", {5'd0, state_code}, 8'd0);
        chk("R1 trig", {7'd0, trig_pulse}, 8'd0);
        chk("R1 brk", {5'd0, brk_req}, 8'd0);
        chan_hit = '0; brk_en = '0;
        rst = 1'b0; tick();
    endtask

    task automatic t_walk();
        arm_en = 1'b1; tick();
        chk("R2 arm edge", {5'd0, state_code}, 8'd1);
        hit_once(3'b001); chk("R4 s1 ch0", {5'd0, state_code}, 8'd2);
        hit_once(3'b001); chk("R4 s2 ch0", {5'd0, state_code}, 8'd3);
        hit_once(3'b100); chk("R4 s3 ch2", {5'd0, state_code}, 8'd1);
        hit_once(3'b010); chk("R4 s1 ch1", {5'd0, state_code}, 8'd3);
        hit_once(3'b001);
        chk("R4 s3 to final", {5'd0, state_code}, 8'd4);
        chk("R9 trig high", {7'd0, trig_pulse}, 8'd1);
        chan_hit = 3'b111; tick(); chan_hit = '0;
        chk("R8 final to idle", {5'd0, state_code}, 8'd0);
        chk("R9 trig low", {7'd0, trig_pulse}, 8'd0);
        tick(); tick();
        chk("R2 no rearm held", {5'd0, state_code}, 8'd0);
        hit_once(3'b111);
        chk("R11 idle ignores", {5'd0, state_code}, 8'd0);
    endtask

    task automatic t_priority();
        rearm();
        hit_once(3'b011); chk("R5 lowest wins", {5'd0, state_code}, 8'd2);
        hit_once(3'b010); chk("R4 s2 ch1", {5'd0, state_code}, 8'd1);
        hit_once(3'b101);
        chk("R5 final wins", {5'd0, state_code}, 8'd4);
        chk("R9 trig prio", {7'd0, trig_pulse}, 8'd1);
        tick();
    endtask

    task automatic t_drop();
        rearm();
        hit_once(3'b011);
        tick(); tick(); tick();
        chk("R6 loser dropped", {5'd0, state_code}, 8'd2);
    endtask

    task automatic t_ignore();
        hit_once(3'b100); chk("R4 zero target", {5'd0, state_code}, 8'd2);
        set_tgt(2, 2, 3'b110);
        hit_once(3'b100); chk("R4 reserved target", {5'd0, state_code}, 8'd2);
        set_tgt(2, 2, 3'b000);
        arm_en = 1'b0; tick();
        hit_once(3'b111);
        chk("R11 disarmed ignores", {5'd0, state_code}, 8'd0);
    endtask

    task automatic t_force();
        arm_en = 1'b1; tick();
        force_trig = 1'b1; chan_hit = 3'b001; tick();
        force_trig = 1'b0; chan_hit = '0;
        chk("R7 force to final", {5'd0, state_code}, 8'd4);
        chk("R9 trig force", {7'd0, trig_pulse}, 8'd1);
        tick();
        chk("R8 after force", {5'd0, state_code}, 8'd0);
        force_trig = 1'b1; tick(); force_trig = 1'b0;
        chk("R7 idle force ignored", {5'd0, state_code}, 8'd0);
        chk("R7 idle no trig", {7'd0, trig_pulse}, 8'd0);
    endtask

    task automatic t_disarm();
        rearm();
        hit_once(3'b001);
        arm_en = 1'b0; chan_hit = 3'b100; tick(); chan_hit = '0;
        chk("R3 disarm", {5'd0, state_code}, 8'd0);
        chk("R3 no trig", {7'd0, trig_pulse}, 8'd0);
    endtask

    task automatic t_brk();
        brk_en = 3'b101; chan_hit = 3'b111; #1;
        chk("R10 brk disarmed", {5'd0, brk_req}, 8'h05);
        tick(); chan_hit = '0; #1;
        chk("R10 brk clears", {5'd0, brk_req}, 8'h00);
        chk("R10 state kept", {5'd0, state_code}, 8'd0);
        arm_en = 1'b1; tick();
        brk_en = 3'b010; chan_hit = 3'b011; #1;
        chk("R10 brk armed", {5'd0, brk_req}, 8'h02);
        tick(); chan_hit = '0;
        chk("R10 seq still moves", {5'd0, state_code}, 8'd2);
        brk_en = '0;
    endtask

    initial begin
        // state 1: ch0->2, ch1->3, ch2->final
        set_tgt(1, 0, 3'd2); set_tgt(1, 1, 3'd3); set_tgt(1, 2, 3'd4);
        // state 2: ch0->3, ch1->1, ch2 ignored
        set_tgt(2, 0, 3'd3); set_tgt(2, 1, 3'd1); set_tgt(2, 2, 3'd0);
        // state 3: ch0->final, ch1 ignored, ch2->1
        set_tgt(3, 0, 3'd4); set_tgt(3, 1, 3'd0); set_tgt(3, 2, 3'd1);
        @(negedge clk);
        t_reset();
        t_walk();
        t_priority();
        t_drop();
        t_ignore();
        t_force();
        t_disarm();
        t_brk();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule